// File: doc/BRIEF.md
# DDR Serial Lane Deserializer

This block turns one high-speed serial lane into 8-bit parallel words. The lane is sampled on both edges of a fast bit clock, so each bit-clock period delivers two serial bits. The two samples of each period are split into an early stream (taken at the falling edge) and a late stream (taken at the rising edge). Each stream feeds its own 4-bit shift register, so each register fills at half the serial rate.

A word clock runs at one quarter of the bit clock, in a fixed phase: its rising and falling edges fall on bit-clock falling edges. On each word-clock rising edge an output register takes both half-words and interleaves them into one parallel word for the core logic. A clock enable freezes the capture and shift stages. A synchronous active-high reset clears every stage. Clock generation, pad behaviour and word alignment are handled outside the block.

Top module: `lvds_ddr_deser`

## Requirements
- R1: A high `rst` at a bit-clock rising or falling edge clears the capture and shift registers. A high `rst` at a word-clock rising edge sets `pword` to zero. Right after reset is released, the output shows zero, with no residue from data taken before the reset.
- R2: When `bit_en` is high, `sdin` is sampled at every bit-clock falling edge (early sample) and at every bit-clock rising edge (late sample). The early sample and the following late sample are handed on together as one pair at that rising edge.
- R3: Bits are placed MSB first. The first serial bit of a word lands in `pword[7]`. Early samples fill the odd positions 2k+1 and late samples fill the even positions 2k. Pairs received earlier take the higher positions, so pair j of a word (j = 0..3) gives bits 7-2j (early) and 6-2j (late).
- R4: Let F be a word-clock falling edge. One word is made of the eight samples taken at the bit-clock edges that start at the bit-clock falling edge after F and end at the rising edge 3.5 bit periods later. That word appears on `pword` at the second word-clock rising edge after F.
- R5: `pword` changes only at word-clock rising edges. Each word stays stable for a full word-clock period.
- R6: While `bit_en` is low, the capture and shift registers hold their values and `sdin` is ignored. The output keeps presenting the word held in the shift registers once per word period. When `bit_en` returns, the stream continues with no lost or repeated bit.
- R7: Words sent back to back with no gap come out on consecutive word-clock rising edges, with no slip in the word boundary.
- R8: After a reset taken in the middle of a stream, a stream restarted per the R4 framing yields correct words from its very first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Fast bit clock; both edges sample the lane |
| clk_word | input | 1 | Word clock, one quarter of the bit clock, edges on bit-clock falling edges |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| bit_en | input | 1 | Clock enable for the capture and shift stages |
| sdin | input | 1 | Serial lane data |
| pword | output | 8 | Reassembled parallel word |

## Verification
Some checks run on every bit-clock cycle: the late-sample path from the lane pin into the even-bit shift register, the freeze of the capture pair and both shift registers while the enable is low, and the zeroing of the shift and output stages after reset. Other behaviour is only shown by the bench scenarios. These cover the MSB-first interleave, the word framing and two-word-clock latency against the word-clock phase, back-to-back streaming, the held output word and seamless resume around an enable pause, and clean recovery after a reset in the middle of a stream. The early sample crosses to the opposite clock edge, so its path is judged only through the words the bench compares.

// File: rtl/lvds_ddr_pkg.sv
package lvds_ddr_pkg;

    // Default number of bit-clock cycles per parallel word (two bits per cycle).
    localparam int DEF_RATIO = 4;

    // One bit-clock period of lane data: the falling-edge sample comes first.
    typedef struct packed {
        logic early;
        logic late;
    } edge_pair_t;

    // Which half of the word a shift register builds.
    typedef enum logic {
        STREAM_ODD  = 1'b0,
        STREAM_EVEN = 1'b1
    } stream_e;

    // Route the sample of a pair that belongs to the given half-word.
    function automatic logic pick_bit(edge_pair_t p, stream_e s);
        return (s == STREAM_ODD) ? p.early : p.late;
    endfunction

endpackage

// File: rtl/lvds_ddr_capture.sv
module lvds_ddr_capture
    import lvds_ddr_pkg::*;
(
    input  logic       clk_bit,
    input  logic       rst,
    input  logic       ce,
    input  logic       din,
    output edge_pair_t pair
);

    logic       fall_q;
    edge_pair_t pair_q;

    // Falling-edge stage: holds the early sample until the next rising edge.
    always_ff @(negedge clk_bit) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else if (ce) begin
            fall_q <= din;
        end
    end

    // Rising-edge stage: early and late samples leave together.
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            pair_q <= '0;
        end else if (ce) begin
            pair_q.early <= fall_q;
            pair_q.late  <= din;
        end
    end

    assign pair = pair_q;

    // R6
    cap_hold_chk: assert property (@(posedge clk_bit) disable iff (rst)
        !ce |=> $stable(pair_q));

endmodule

// File: rtl/lvds_ddr_half_shift.sv
module lvds_ddr_half_shift #(
    parameter int DEPTH = 4
) (
    input  logic             clk_bit,
    input  logic             rst,
    input  logic             ce,
    input  logic             bit_in,
    output logic [DEPTH-1:0] q
);

    logic [DEPTH-1:0] q_r;
    logic             rst_seen_q = 1'b0;

    // Left shift: the oldest sample ends in the top bit after DEPTH shifts.
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            q_r <= '0;
        end else if (ce) begin
            q_r <= {q_r[DEPTH-2:0], bit_in};
        end
    end

    assign q = q_r;

    // R1: one edge after reset was seen, the register must read zero.
    always_ff @(posedge clk_bit) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            shreg_rst_chk: assert (q_r == '0);
        end
    end

    // R6
    sr_hold_chk: assert property (@(posedge clk_bit) disable iff (rst)
        !ce |=> $stable(q_r));

endmodule

// File: rtl/lvds_ddr_word_reg.sv
module lvds_ddr_word_reg #(
    parameter int RATIO = 4
) (
    input  logic               clk_word,
    input  logic               rst,
    input  logic [RATIO-1:0]   odd_bits,
    input  logic [RATIO-1:0]   even_bits,
    output logic [2*RATIO-1:0] word
);

    localparam int WORD_W = 2 * RATIO;

    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic              rst_seen_q = 1'b0;

    // Fixed re-interleave of the two half-words.
    for (genvar k = 0; k < RATIO; k++) begin : g_weave
        assign merged[2*k+1] = odd_bits[k];
        assign merged[2*k]   = even_bits[k];
    end

    always_ff @(posedge clk_word) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= merged;
        end
    end

    assign word = word_q;

    // R1: a word-clock edge under reset leaves the output at zero.
    always_ff @(posedge clk_word) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            word_rst_chk: assert (word_q == '0);
        end
    end

endmodule

// File: rtl/lvds_ddr_deser.sv
module lvds_ddr_deser
    import lvds_ddr_pkg::*;
#(
    parameter int RATIO = DEF_RATIO
) (
    input  logic               clk_bit,
    input  logic               clk_word,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               sdin,
    output logic [2*RATIO-1:0] pword
);

    localparam int N_HALF = 2;

    edge_pair_t       pair;
    logic [RATIO-1:0] half_q [N_HALF];
    logic [1:0]       live_q;

    lvds_ddr_capture u_capture (
        .clk_bit (clk_bit),
        .rst     (rst),
        .ce      (bit_en),
        .din     (sdin),
        .pair    (pair)
    );

    for (genvar s = 0; s < N_HALF; s++) begin : g_half
        localparam stream_e SEL = stream_e'(s);
        logic bit_in;
        assign bit_in = pick_bit(pair, SEL);

        lvds_ddr_half_shift #(
            .DEPTH (RATIO)
        ) u_shift (
            .clk_bit (clk_bit),
            .rst     (rst),
            .ce      (bit_en),
            .bit_in  (bit_in),
            .q       (half_q[s])
        );
    end

    lvds_ddr_word_reg #(
        .RATIO (RATIO)
    ) u_word (
        .clk_word  (clk_word),
        .rst       (rst),
        .odd_bits  (half_q[int'(STREAM_ODD)]),
        .even_bits (half_q[int'(STREAM_EVEN)]),
        .word      (pword)
    );

    // Cycles since reset, saturating; keeps $past inside the live window.
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            live_q <= '0;
        end else if (live_q != 2'd3) begin
            live_q <= live_q + 2'd1;
        end
    end

    // R2: a late sample reaches the even shift register two enabled edges on.
    lo_path_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (live_q == 2'd3) && bit_en && $past(bit_en)
        |=> half_q[int'(STREAM_EVEN)][0] == $past(sdin, 2));

endmodule

// File: tb/tb_lvds_ddr_deser.sv
`timescale 1ns/1ps
module tb_lvds_ddr_deser;

    logic       clk_bit  = 1'b0;
    logic       clk_word = 1'b0;
    logic       rst      = 1'b1;
    logic       bit_en   = 1'b0;
    logic       sdin     = 1'b0;
    logic [7:0] pword;

    int         n_cmp  = 0;
    int         n_bad  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_on = 1'b0;
    int         skip   = 0;
    logic [7:0] last_word = 8'h00;
    logic [7:0] mon_e;
    string      mon_t;
    logic [7:0] lfsr = 8'h5B;
    bit         done = 1'b0;

    lvds_ddr_deser dut (
        .clk_bit  (clk_bit),
        .clk_word (clk_word),
        .rst      (rst),
        .bit_en   (bit_en),
        .sdin     (sdin),
        .pword    (pword)
    );

    // 200 MHz bit clock; word clock edges land on bit-clock falling edges.
    always #2.5 clk_bit = ~clk_bit;
    initial begin
        #10;
        forever begin
            clk_word = 1'b1; #10;
            clk_word = 1'b0; #10;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: one expected word per word period, read at the falling edge.
    always @(negedge clk_word) begin
        if (mon_on) begin
            if (skip > 0) begin
                skip = skip - 1;
            end else if (exp_q.size() > 0) begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, pword, mon_e);
                #9;
                check({"R5 stable until next rise, ", mon_t}, pword, mon_e);
            end
        end
    end

    task automatic send_pair(logic a, logic b);
        @(posedge clk_bit); #1.25; sdin = a;
        @(negedge clk_bit); #1.25; sdin = b;
    endtask

    // Driver: pushes the expected word; an optional enable pause at pair 1.
    task automatic send_word(logic [7:0] w, string tag, int hold = 0);
        for (int j = 0; j < 4; j++) begin
            if (j == 1 && hold > 0) begin
                @(posedge clk_bit); #1.25; bit_en = 1'b0;
                for (int h = 0; h < hold; h++) begin
                    exp_q.push_back(last_word);
                    tag_q.push_back("R6 word held while enable low");
                end
                for (int c = 0; c < 4 * hold; c++) begin
                    @(posedge clk_bit); #1.25; sdin = ~sdin;
                end
                bit_en = 1'b1;
                sdin = w[7-2*j];
                @(negedge clk_bit); #1.25; sdin = w[6-2*j];
            end else begin
                send_pair(w[7-2*j], w[6-2*j]);
            end
        end
        exp_q.push_back(w);
        tag_q.push_back(tag);
        last_word = w;
    endtask

    task automatic sync_stream();
        @(negedge clk_word); #0.5;
        mon_on = 1'b1;
        skip   = 1;
    endtask

    task automatic end_stream();
        while (exp_q.size() != 0) @(negedge clk_word);
        #12;
        mon_on = 1'b0;
        sdin   = 1'b0;
    endtask

    initial begin
        // R1: output under reset
        repeat (12) @(posedge clk_bit);
        @(negedge clk_word); #1;
        check("R1 output zero during reset", pword, 8'h00);
        @(posedge clk_bit); #1.25;
        rst    = 1'b0;
        bit_en = 1'b1;
        repeat (4) @(posedge clk_bit);

        sync_stream();
        send_word(8'hA5, "R4 first word latency and framing");
        send_word(8'h5A, "R2 R3 alternating pattern");
        send_word(8'h80, "R3 first serial bit to bit 7");
        send_word(8'h01, "R3 last serial bit to bit 0");
        send_word(8'hFF, "R7 all ones back to back");
        send_word(8'h00, "R7 all zeros back to back");
        send_word(8'hAA, "R2 early samples only (odd bits)");
        send_word(8'h55, "R2 late samples only (even bits)");
        for (int k = 0; k < 8; k++) begin
            send_word(8'h01 << k, "R3 walking one");
        end
        send_word(8'hC3, "R7 before enable pause");
        send_word(8'h96, "R6 resume after enable pause", 2);
        send_word(8'h69, "R7 continuation after pause");
        for (int k = 0; k < 6; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send_word(lfsr, "R7 pseudo-random stream");
        end
        end_stream();

        // R8: reset in the middle of a stream of ones
        repeat (6) send_pair(1'b1, 1'b1);
        @(posedge clk_bit); #1.25; rst = 1'b1;
        repeat (12) @(posedge clk_bit);
        @(negedge clk_word); #1;
        check("R8 reset mid-stream clears output", pword, 8'h00);
        sdin = 1'b0;
        // release just before a word-clock rise, with no shift in between
        @(negedge clk_word);
        @(posedge clk_bit);
        @(posedge clk_bit); #1.25; rst = 1'b0;
        @(negedge clk_word); #1;
        check("R1 shift stages cleared by reset", pword, 8'h00);

        sync_stream();
        send_word(8'h3C, "R8 first word after reset");
        send_word(8'hE7, "R8 second word after reset");
        send_word(8'h18, "R8 third word after reset");
        end_stream();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule